// File: doc/BRIEF.md
# Branch Target Predictor with Two-Bit Hysteresis

This block is a direct-mapped table the fetch stage consults every cycle. Each lookup presents the current fetch address. An entry stores three things: the full address of a branch instruction, that branch's target, and a two-bit saturating confidence counter. When the fetch address matches a valid entry whose counter leans taken, the block answers "taken" and supplies the stored target. In every other case it answers "not taken" and supplies the next sequential address, which is the fetch address plus the instruction size.

Branches resolve later in the pipe and report back through a separate update port. A taken branch that is not in the table claims its slot and overwrites any previous occupant. A resolved branch that is already in the table moves its counter one step. A not-taken branch that is absent leaves the table untouched.

The two-bit hysteresis means a strongly taken branch survives a single opposite outcome, such as a loop exit, and keeps predicting taken. The table is held in dedicated registers, so a lookup needs no memory access.

Top module: `branch_target_predictor`

## Requirements
- R1: After reset every entry is invalid, so any lookup gives pred_taken = 0 and pred_target = lookup_pc + INST_BYTES.
- R2: A lookup whose address equals the stored branch address of a valid entry with counter 2'b10 or 2'b11 gives pred_taken = 1 and pred_target equal to the stored target. A taken update to an entry that is already present replaces its stored target with upd_target.
- R3: Whenever pred_taken = 0, pred_target equals lookup_pc + INST_BYTES. This covers a miss and a valid match whose counter is 2'b00 or 2'b01.
- R4: A taken update that misses allocates the entry at index (upd_pc / INST_BYTES) mod DEPTH with counter 2'b10 (weakly taken), so that one later not-taken update makes it predict not taken.
- R5: The counter saturates. A taken outcome at 2'b11 stays at 2'b11, and a not-taken outcome at 2'b00 stays at 2'b00. A branch driven to 2'b00 therefore needs exactly two taken outcomes before it predicts taken again.
- R6: A branch at 2'b11 that sees one not-taken outcome still predicts taken, so an isolated loop exit costs a single misprediction.
- R7: A not-taken update that misses changes nothing: a different branch already in that slot keeps its prediction, and the reported address is not allocated.
- R8: A lookup that selects a valid entry holding a different full branch address (same index, different tag) predicts not taken.
- R9: When an update and a lookup reach the same entry in the same cycle, the lookup sees the state from before the update. The new state becomes visible from the next cycle on.
- R10: A taken update that misses on an occupied slot evicts the previous branch. The new address then hits and the evicted address misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all valid bits |
| lookup_pc | input | ADDR_W | Fetch address queried this cycle |
| pred_taken | output | 1 | Predicted direction for lookup_pc |
| pred_target | output | ADDR_W | Next fetch address: stored target or lookup_pc + INST_BYTES |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The counter is never visible at the ports, so its value has to be inferred from the sequence of predictions. The bench does this by driving a branch into a known extreme, 2'b11 with extra taken outcomes or 2'b00 with extra not-taken outcomes, and then counting how many opposite outcomes flip the prediction. The hardest case is the same-cycle collision of R9. There, the lookup and the update for one address are held together across a single rising edge. The prediction is sampled once before that edge and once after it, while the update is still asserted but has been applied only once.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_ALLOC = CTR_WEAK_T;

    function automatic logic ctr_says_taken(input ctr_t s);
        return s[1];
    endfunction

    function automatic ctr_t ctr_step(input ctr_t s, input logic taken);
        ctr_t r;
        r = s;
        if (taken) begin
            case (s)
                CTR_STRONG_NT: r = CTR_WEAK_NT;
                CTR_WEAK_NT:   r = CTR_WEAK_T;
                CTR_WEAK_T:    r = CTR_STRONG_T;
                default:       r = CTR_STRONG_T;
            endcase
        end else begin
            case (s)
                CTR_STRONG_T:  r = CTR_WEAK_T;
                CTR_WEAK_T:    r = CTR_WEAK_NT;
                CTR_WEAK_NT:   r = CTR_STRONG_NT;
                default:       r = CTR_STRONG_NT;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 16,
    parameter int INST_BYTES = 4,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OFS       = (INST_BYTES > 1) ? $clog2(INST_BYTES) : 0
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = IDX_W'(pc >> OFS);
    end
endmodule

// File: rtl/bht_store.sv
module bht_store
    import bht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    // lookup read port
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [ADDR_W-1:0] ra_tag,
    output logic [ADDR_W-1:0] ra_tgt,
    output ctr_t              ra_ctr,
    // update read port
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [ADDR_W-1:0] rb_tag,
    output logic [ADDR_W-1:0] rb_tgt,
    output ctr_t              rb_ctr,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  ctr_t              wr_ctr,
    output logic [DEPTH-1:0]  valid_vec
);
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    ctr_t              ctr_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (sel) begin
                valid_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[i] <= wr_tag;
                tgt_q[i] <= wr_tgt;
                ctr_q[i] <= wr_ctr;
            end
        end
    end

    always_comb begin
        ra_valid = valid_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        ra_tgt   = tgt_q[ra_idx];
        ra_ctr   = ctr_q[ra_idx];
        rb_valid = valid_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
        rb_tgt   = tgt_q[rb_idx];
        rb_ctr   = ctr_q[rb_idx];
    end

    assign valid_vec = valid_q;
endmodule

// File: rtl/bht_update.sv
module bht_update
    import bht_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0] ent_tgt,
    input  ctr_t              ent_ctr,
    output logic              hit,
    output logic              alloc,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_tag,
    output logic [ADDR_W-1:0] wr_tgt,
    output ctr_t              wr_ctr
);
    always_comb begin
        hit    = upd_valid && ent_valid && (ent_tag == upd_pc);
        alloc  = upd_valid && !hit && upd_taken;
        wr_en  = hit || alloc;
        wr_tag = upd_pc;
        wr_tgt = ent_tgt;
        wr_ctr = ent_ctr;
        if (hit) begin
            wr_ctr = ctr_step(ent_ctr, upd_taken);
            if (upd_taken) begin
                wr_tgt = upd_target;
            end
        end else if (alloc) begin
            wr_ctr = CTR_ALLOC;
            wr_tgt = upd_target;
        end
    end
endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 16,
    parameter int INST_BYTES = 4,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lookup_pc,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic              ra_valid, rb_valid;
    logic [ADDR_W-1:0] ra_tag, ra_tgt, rb_tag, rb_tgt;
    ctr_t              ra_ctr, rb_ctr;
    logic              u_hit, u_alloc, u_wr;
    logic [ADDR_W-1:0] u_tag, u_tgt;
    ctr_t              u_ctr;
    logic [DEPTH-1:0]  valid_vec;
    logic              lk_hit;

    bht_index #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .INST_BYTES(INST_BYTES)) u_lk_idx (
        .pc(lookup_pc), .idx(lk_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .INST_BYTES(INST_BYTES)) u_up_idx (
        .pc(upd_pc), .idx(up_idx)
    );

    bht_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .ra_idx(lk_idx), .ra_valid(ra_valid), .ra_tag(ra_tag), .ra_tgt(ra_tgt), .ra_ctr(ra_ctr),
        .rb_idx(up_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_tgt(rb_tgt), .rb_ctr(rb_ctr),
        .wr_en(u_wr), .wr_idx(up_idx), .wr_tag(u_tag), .wr_tgt(u_tgt), .wr_ctr(u_ctr),
        .valid_vec(valid_vec)
    );

    bht_update #(.ADDR_W(ADDR_W)) u_update (
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
        .ent_valid(rb_valid), .ent_tag(rb_tag), .ent_tgt(rb_tgt), .ent_ctr(rb_ctr),
        .hit(u_hit), .alloc(u_alloc), .wr_en(u_wr),
        .wr_tag(u_tag), .wr_tgt(u_tgt), .wr_ctr(u_ctr)
    );

    always_comb begin
        lk_hit      = ra_valid && (ra_tag == lookup_pc);
        pred_taken  = lk_hit && ctr_says_taken(ra_ctr);
        pred_target = pred_taken ? ra_tgt : (lookup_pc + ADDR_W'(INST_BYTES));
    end

    // R1: one cycle after reset no entry can produce a taken prediction
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_taken && valid_vec == '0));

    // R2: a taken prediction needs a valid entry in the selected slot
    assert_taken_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> valid_vec[lk_idx]);

    // R4: an allocation leaves the addressed slot valid on the next cycle
    assert_alloc_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
        u_alloc |=> valid_vec[$past(up_idx)]);

    // R7: a not-taken miss leaves the valid bits untouched
    assert_no_alloc_on_nt_miss_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !u_hit) |=> $stable(valid_vec));

endmodule

// File: tb/tb_branch_target_predictor.sv
module tb_branch_target_predictor;
    localparam int AW = 32;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lookup_pc = '0;
    logic          pred_taken;
    logic [AW-1:0] pred_target;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    branch_target_predictor #(.ADDR_W(AW), .DEPTH(16), .INST_BYTES(STEP)) dut (
        .clk(clk), .rst(rst), .lookup_pc(lookup_pc),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    task automatic expect_pred(input logic [AW-1:0] pc, input logic et,
                               input logic [AW-1:0] etgt, input string req);
        logic [AW-1:0] want;
        @(negedge clk);
        lookup_pc = pc;
        #1;
        want = et ? etgt : pc + STEP;
        n_checks++;
        if (pred_taken !== et || pred_target !== want) begin
            n_fail++;
            $display("FAIL %s pc=%h got taken=%0b tgt=%h expected taken=%0b tgt=%h",
                     req, pc, pred_taken, pred_target, et, want);
        end
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input logic t, input logic [AW-1:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        expect_pred(32'h0000_1000, 0, 0, "R1");
        expect_pred(32'h0000_003C, 0, 0, "R1");
        expect_pred(32'hFFFF_FFF0, 0, 0, "R3");
    endtask

    task automatic t_alloc();
        resolve(32'h1000, 1, 32'h2000);
        expect_pred(32'h1000, 1, 32'h2000, "R4");
        resolve(32'h1000, 0, 0);
        expect_pred(32'h1000, 0, 0, "R4");
        resolve(32'h1000, 1, 32'h3000);
        expect_pred(32'h1000, 1, 32'h3000, "R2");
    endtask

    task automatic t_saturate();
        resolve(32'h1004, 1, 32'h5000);
        for (int i = 0; i < 4; i++) resolve(32'h1004, 1, 32'h5000);
        resolve(32'h1004, 0, 0);
        expect_pred(32'h1004, 1, 32'h5000, "R5");
        resolve(32'h1004, 0, 0);
        expect_pred(32'h1004, 0, 0, "R3");
        for (int i = 0; i < 4; i++) resolve(32'h1004, 0, 0);
        resolve(32'h1004, 1, 32'h5000);
        expect_pred(32'h1004, 0, 0, "R5");
        resolve(32'h1004, 1, 32'h5000);
        expect_pred(32'h1004, 1, 32'h5000, "R5");
    endtask

    task automatic t_loop_exit();
        resolve(32'h1008, 1, 32'h0F00);
        resolve(32'h1008, 1, 32'h0F00);
        resolve(32'h1008, 0, 0);
        expect_pred(32'h1008, 1, 32'h0F00, "R6");
        resolve(32'h1008, 1, 32'h0F00);
        expect_pred(32'h1008, 1, 32'h0F00, "R6");
    endtask

    task automatic t_no_alloc();
        resolve(32'h2010, 0, 32'h7777);
        expect_pred(32'h2010, 0, 0, "R7");
        resolve(32'h2014, 1, 32'h8000);
        resolve(32'h2054, 0, 32'h9999);
        expect_pred(32'h2014, 1, 32'h8000, "R7");
        expect_pred(32'h2054, 0, 0, "R7");
    endtask

    task automatic t_alias();
        resolve(32'h1100, 1, 32'hA000);
        expect_pred(32'h1140, 0, 0, "R8");
        expect_pred(32'h1100, 1, 32'hA000, "R8");
        resolve(32'h1140, 1, 32'hB000);
        expect_pred(32'h1140, 1, 32'hB000, "R10");
        expect_pred(32'h1100, 0, 0, "R10");
    endtask

    task automatic t_same_cycle();
        resolve(32'h1018, 1, 32'hC000);
        resolve(32'h1018, 0, 0);
        @(negedge clk);
        lookup_pc = 32'h1018;
        upd_valid = 1'b1; upd_pc = 32'h1018; upd_taken = 1'b1; upd_target = 32'hC000;
        #1;
        n_checks++;
        if (pred_taken !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 before edge got taken=%0b expected taken=0", pred_taken);
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (pred_taken !== 1'b1 || pred_target !== 32'hC000) begin
            n_fail++;
            $display("FAIL R9 after edge got taken=%0b tgt=%h expected taken=1 tgt=%h",
                     pred_taken, pred_target, 32'hC000);
        end
        @(negedge clk);
        upd_valid = 1'b0;
        expect_pred(32'h1018, 1, 32'hC000, "R9");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alloc();
        t_saturate();
        t_loop_exit();
        t_no_alloc();
        t_alias();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule